// File: doc/BRIEF.md
# Rolling-Shutter Pixel Array Readout Sequencer

This block produces the control timing for an image sensor array that is read one row at a time. Each row gets a time slot. In that slot the sequencer drives the row reset, transfer-gate, row-select and column-sample strobes in the order that the selected pixel type needs. It then steps a column address so that the column storage of that row leaves the array serially, one pixel per clock, with a pixel-valid strobe. Rows follow each other with no gap. Each row's integration window therefore starts one row slot later than the window of the row before it, which gives a rolling shutter.

Three pixel types are supported. The first is a three-transistor photodiode pixel, whose row reset comes after the row has been read. The second is a pinned-diode pixel with a transfer gate: its floating node is reset, then charge is transferred, then the row is sampled. The third is a shared-diffusion pixel: several transfer gates sit on one floating diffusion, the column line is pulled high to reset the diffusion, and the column line is pulled low at the end to park the diffusion. The integration time is set in row slots. A separate shutter-reset strobe names the row that is that many slots ahead of the row being read. The array size, settle time, integration and pixel type are taken when a frame begins and are held for the whole frame.

Top module: `rs_readout_seq`

## Requirements
- R1: While reset is high, and while idle after reset, every strobe is low and `busy` is low. `row_addr`, `fd_group`, `col_addr`, `tx_lane` and `shut_row` are all zero.
- R2: When `start` is sampled high while idle, the first cycle of the slot for row 0 appears on the next clock. `frame_start` is high in that cycle only, and `row_addr` is 0.
- R3: `pix_mode` = 0 (three-transistor) gives this slot: `row_sel` for the settle cycles, then one cycle of `row_sel` with `col_sample`, then one cycle of `row_reset` alone, then the column scan.
- R4: `pix_mode` = 1 (pinned diode), and also code 3, gives this slot: one cycle of `row_reset`, one cycle of `row_tx`, `row_sel` for the settle cycles, one cycle of `row_sel` with `col_sample`, then the column scan.
- R5: `pix_mode` = 2 (shared diffusion) gives this slot: one cycle of `row_sel` with `col_pull_hi`, one cycle of `row_tx` with `row_sel`, `row_sel` for the settle cycles, one cycle of `row_sel` with `col_sample`, one cycle of `row_sel` with `col_pull_lo`, then the column scan. `row_reset` is never raised in this mode.
- R6: The settle phase lasts `cfg_settle` cycles before `col_sample`. A value of 0 gives one cycle.
- R7: The column scan lasts `cfg_cols` cycles with `pix_valid` high. `col_addr` counts 0, 1, ... `cfg_cols`-1 in those cycles.
- R8: The slot for the next row starts on the clock after the last scan cycle, and `row_addr` goes up by one. `tx_lane` is one-hot on bit `row_addr` mod 4 while `row_tx` is high and is zero otherwise. `fd_group` equals `row_addr` divided by 4.
- R9: When 0 < `cfg_integ` < `cfg_rows`, `shut_reset` is high in the first cycle of each slot, with `shut_row` = (`row_addr` + `cfg_integ`) mod `cfg_rows`. For any other value, `shut_reset` stays low.
- R10: After the last scan cycle of row `cfg_rows`-1 comes one cycle with `frame_end` high and `busy` high. If `start` was high at that clock, row 0 of the next frame follows directly.
- R11: If `start` is sampled low at the end of a row, the sequencer returns to idle on the next clock. A row already started always completes, including its scan.
- R12: The configuration inputs are captured when a frame begins. Changing them during a frame has no effect until the next frame begins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Run request; low ends the sequence after the current row |
| pix_mode | input | 2 | Pixel type: 0 three-transistor, 1 or 3 pinned diode, 2 shared diffusion |
| cfg_rows | input | ROW_W | Rows per frame (nonzero) |
| cfg_cols | input | COL_W | Columns per row (nonzero) |
| cfg_settle | input | SET_W | Row transfer settle cycles before sampling |
| cfg_integ | input | ROW_W | Integration time in row slots |
| busy | output | 1 | A frame is in progress |
| row_addr | output | ROW_W | Row being read |
| fd_group | output | ROW_W-SHARE_LOG | Shared floating diffusion group of the row |
| row_reset | output | 1 | Row reset strobe |
| row_tx | output | 1 | Transfer-gate strobe |
| tx_lane | output | 2**SHARE_LOG | Which transfer gate of the group is pulsed |
| row_sel | output | 1 | Row select |
| col_pull_hi | output | 1 | Column line pulled high (diffusion reset) |
| col_pull_lo | output | 1 | Column line pulled low (diffusion park) |
| col_sample | output | 1 | Column storage sample strobe |
| col_addr | output | COL_W | Column being read |
| pix_valid | output | 1 | A pixel of the current row is on the column mux |
| shut_reset | output | 1 | Rolling shutter reset strobe |
| shut_row | output | ROW_W | Row that the shutter reset addresses |
| frame_start | output | 1 | First cycle of row 0 |
| frame_end | output | 1 | Cycle after the last pixel of the frame |

## Verification
Every output is decoded from registers only. A start or stop decision sampled at one clock edge therefore shows on the outputs right after that edge, and every later phase follows at a fixed count of cycles. For example, a pinned-diode slot with settle S and C columns lasts S+3+C cycles, and `frame_end` comes one cycle after the last `pix_valid`. The bench model records the inputs at each rising edge. When the list of expected cycles for the current slot runs out, the model decides on the next slot from those recorded inputs and fills the list again. The model compares one entry with every output at each falling edge. As a result, a strobe that comes one cycle early or late, or in the wrong order, fails in the cycle where the difference shows.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

  typedef enum logic [1:0] {
    PIX_3T     = 2'd0,
    PIX_PINNED = 2'd1,
    PIX_SHARED = 2'd2,
    PIX_ALT    = 2'd3
  } pix_mode_e;

  typedef enum logic [3:0] {
    PH_IDLE = 4'd0,
    PH_RST  = 4'd1,
    PH_TX   = 4'd2,
    PH_SEL  = 4'd3,
    PH_SMP  = 4'd4,
    PH_RST3 = 4'd5,
    PH_PARK = 4'd6,
    PH_SCAN = 4'd7,
    PH_END  = 4'd8
  } phase_e;

  // first phase of a row slot for a given pixel type
  function automatic phase_e slot_entry(input logic [1:0] m);
    return (m == PIX_3T) ? PH_SEL : PH_RST;
  endfunction

  function automatic logic mode_shared(input logic [1:0] m);
    return m == PIX_SHARED;
  endfunction

endpackage

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
  import rsq_pkg::*;
#(
  parameter int SET_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [1:0]       mode_in,
  input  logic [1:0]       mode_q,
  input  logic [SET_W-1:0] settle_in,
  input  logic [SET_W-1:0] settle_q,
  input  logic             col_last,
  input  logic             row_last,
  output phase_e           phase,
  output logic             slot_first,
  output logic             frame_go,
  output logic             row_go,
  output logic             scan_go
);

  phase_e           nxt;
  logic [SET_W-1:0] cnt;
  logic [1:0]       mode_eff;
  logic [SET_W-1:0] settle_eff;
  logic [SET_W-1:0] settle_ld;
  logic             at_rest;

  // between frames the live inputs apply, inside a frame the captured ones
  assign at_rest    = (phase == PH_IDLE) || (phase == PH_END);
  assign mode_eff   = at_rest ? mode_in : mode_q;
  assign settle_eff = at_rest ? settle_in : settle_q;
  assign settle_ld  = (settle_eff == '0) ? SET_W'(1) : settle_eff;

  always_comb begin
    nxt      = phase;
    frame_go = 1'b0;
    row_go   = 1'b0;
    case (phase)
      PH_IDLE, PH_END: begin
        if (start) begin
          nxt      = slot_entry(mode_eff);
          frame_go = 1'b1;
        end else begin
          nxt = PH_IDLE;
        end
      end
      PH_RST:  nxt = PH_TX;
      PH_TX:   nxt = PH_SEL;
      PH_SEL:  if (cnt == SET_W'(1)) nxt = PH_SMP;
      PH_SMP: begin
        if (mode_q == PIX_3T)          nxt = PH_RST3;
        else if (mode_shared(mode_q))  nxt = PH_PARK;
        else                           nxt = PH_SCAN;
      end
      PH_RST3: nxt = PH_SCAN;
      PH_PARK: nxt = PH_SCAN;
      PH_SCAN: begin
        if (col_last) begin
          if (row_last) begin
            nxt = PH_END;
          end else if (start) begin
            nxt    = slot_entry(mode_q);
            row_go = 1'b1;
          end else begin
            nxt = PH_IDLE;
          end
        end
      end
      default: nxt = PH_IDLE;
    endcase
  end

  assign scan_go = (nxt == PH_SCAN) && (phase != PH_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      cnt        <= '0;
      slot_first <= 1'b0;
    end else begin
      phase      <= nxt;
      slot_first <= frame_go | row_go;
      if ((nxt == PH_SEL) && (phase != PH_SEL)) cnt <= settle_ld;
      else if (phase == PH_SEL)                 cnt <= cnt - SET_W'(1);
    end
  end

endmodule

// File: rtl/rsq_row_track.sv
module rsq_row_track #(
  parameter int ROW_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_go,
  input  logic             row_go,
  input  logic [ROW_W-1:0] rows_q,
  input  logic [ROW_W-1:0] integ_q,
  output logic [ROW_W-1:0] row,
  output logic             row_last,
  output logic             shut_en,
  output logic [ROW_W-1:0] shut_target
);

  logic [ROW_W:0] ahead;
  logic [ROW_W:0] rows_x;

  always_ff @(posedge clk) begin
    if (rst)           row <= '0;
    else if (frame_go) row <= '0;
    else if (row_go)   row <= row + ROW_W'(1);
  end

  assign row_last = (row == rows_q - ROW_W'(1));

  // row is below rows_q, so one conditional subtraction wraps the sum
  assign rows_x      = {1'b0, rows_q};
  assign ahead       = {1'b0, row} + {1'b0, integ_q};
  assign shut_target = ROW_W'((ahead >= rows_x) ? (ahead - rows_x) : ahead);
  assign shut_en     = (integ_q != '0) && (integ_q < rows_q);

endmodule

// File: rtl/rsq_col_scan.sv
module rsq_col_scan #(
  parameter int COL_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_go,
  input  logic             scanning,
  input  logic [COL_W-1:0] cols_q,
  output logic [COL_W-1:0] col,
  output logic             col_last
);

  always_ff @(posedge clk) begin
    if (rst)           col <= '0;
    else if (scan_go)  col <= '0;
    else if (scanning) col <= col + COL_W'(1);
  end

  assign col_last = (col == cols_q - COL_W'(1));

endmodule

// File: rtl/rs_readout_seq.sv
module rs_readout_seq
  import rsq_pkg::*;
#(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 11,
  parameter int SET_W     = 8,
  parameter int SHARE_LOG = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [1:0]                 pix_mode,
  input  logic [ROW_W-1:0]           cfg_rows,
  input  logic [COL_W-1:0]           cfg_cols,
  input  logic [SET_W-1:0]           cfg_settle,
  input  logic [ROW_W-1:0]           cfg_integ,
  output logic                       busy,
  output logic [ROW_W-1:0]           row_addr,
  output logic [ROW_W-SHARE_LOG-1:0] fd_group,
  output logic                       row_reset,
  output logic                       row_tx,
  output logic [(1<<SHARE_LOG)-1:0]  tx_lane,
  output logic                       row_sel,
  output logic                       col_pull_hi,
  output logic                       col_pull_lo,
  output logic                       col_sample,
  output logic [COL_W-1:0]           col_addr,
  output logic                       pix_valid,
  output logic                       shut_reset,
  output logic [ROW_W-1:0]           shut_row,
  output logic                       frame_start,
  output logic                       frame_end
);

  localparam int SHARE_N = 1 << SHARE_LOG;
  localparam int GRP_W   = ROW_W - SHARE_LOG;

  logic [1:0]       mode_q;
  logic [ROW_W-1:0] rows_q;
  logic [COL_W-1:0] cols_q;
  logic [SET_W-1:0] settle_q;
  logic [ROW_W-1:0] integ_q;

  phase_e           phase;
  logic             slot_first, frame_go, row_go, scan_go;
  logic [ROW_W-1:0] row;
  logic             row_last, shut_en;
  logic [ROW_W-1:0] shut_target;
  logic [COL_W-1:0] col;
  logic             col_last;
  logic             shared_q;

  // configuration is frozen for the whole frame
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      rows_q   <= '0;
      cols_q   <= '0;
      settle_q <= '0;
      integ_q  <= '0;
    end else if (frame_go) begin
      mode_q   <= pix_mode;
      rows_q   <= cfg_rows;
      cols_q   <= cfg_cols;
      settle_q <= cfg_settle;
      integ_q  <= cfg_integ;
    end
  end

  rsq_phase_fsm #(.SET_W(SET_W)) fsm_i (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode_in    (pix_mode),
    .mode_q     (mode_q),
    .settle_in  (cfg_settle),
    .settle_q   (settle_q),
    .col_last   (col_last),
    .row_last   (row_last),
    .phase      (phase),
    .slot_first (slot_first),
    .frame_go   (frame_go),
    .row_go     (row_go),
    .scan_go    (scan_go)
  );

  rsq_row_track #(.ROW_W(ROW_W)) rows_i (
    .clk         (clk),
    .rst         (rst),
    .frame_go    (frame_go),
    .row_go      (row_go),
    .rows_q      (rows_q),
    .integ_q     (integ_q),
    .row         (row),
    .row_last    (row_last),
    .shut_en     (shut_en),
    .shut_target (shut_target)
  );

  rsq_col_scan #(.COL_W(COL_W)) cols_i (
    .clk      (clk),
    .rst      (rst),
    .scan_go  (scan_go),
    .scanning (phase == PH_SCAN),
    .cols_q   (cols_q),
    .col      (col),
    .col_last (col_last)
  );

  // outputs decode registered state only
  assign shared_q    = mode_shared(mode_q);
  assign busy        = (phase != PH_IDLE);
  assign row_addr    = busy ? row : '0;
  assign fd_group    = busy ? row[ROW_W-1:SHARE_LOG] : GRP_W'(0);
  assign row_reset   = ((phase == PH_RST) && !shared_q) || (phase == PH_RST3);
  assign row_tx      = (phase == PH_TX);
  assign row_sel     = (phase == PH_SEL) || (phase == PH_SMP) ||
                       (shared_q && ((phase == PH_RST) || (phase == PH_TX) ||
                                     (phase == PH_PARK)));
  assign col_pull_hi = (phase == PH_RST) && shared_q;
  assign col_pull_lo = (phase == PH_PARK);
  assign col_sample  = (phase == PH_SMP);
  assign pix_valid   = (phase == PH_SCAN);
  assign col_addr    = pix_valid ? col : '0;
  assign shut_reset  = slot_first && shut_en;
  assign shut_row    = shut_reset ? shut_target : '0;
  assign frame_start = slot_first && (row == '0);
  assign frame_end   = (phase == PH_END);

  for (genvar g = 0; g < SHARE_N; g++) begin : g_lane
    assign tx_lane[g] = row_tx && (row[SHARE_LOG-1:0] == SHARE_LOG'(g));
  end

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
  parameter int ROW_W   = 10,
  parameter int COL_W   = 11,
  parameter int SHARE_N = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               busy,
  input logic [ROW_W-1:0]   row_addr,
  input logic               row_reset,
  input logic               row_tx,
  input logic [SHARE_N-1:0] tx_lane,
  input logic               row_sel,
  input logic               col_pull_hi,
  input logic               col_pull_lo,
  input logic               col_sample,
  input logic [COL_W-1:0]   col_addr,
  input logic               pix_valid,
  input logic               frame_start,
  input logic               frame_end
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(row_sel || row_reset || row_tx || col_sample || pix_valid));

  p_fstart_row0_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (busy && row_addr == '0));

  p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({row_reset, row_tx, col_sample, pix_valid}));

  p_pull_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(col_pull_hi && col_pull_lo));

  p_sample_after_sel_r6: assert property (@(posedge clk) disable iff (rst)
    col_sample |-> $past(row_sel));

  p_col_step_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_valid)) |-> (col_addr == COL_W'($past(col_addr) + 1'b1)));

  p_lane_onehot_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(tx_lane) == (row_tx ? 1 : 0));

  p_fend_after_scan_r10: assert property (@(posedge clk) disable iff (rst)
    frame_end |-> $past(pix_valid));

endmodule

bind rs_readout_seq rsq_checker #(
  .ROW_W   (ROW_W),
  .COL_W   (COL_W),
  .SHARE_N (SHARE_N)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .row_addr    (row_addr),
  .row_reset   (row_reset),
  .row_tx      (row_tx),
  .tx_lane     (tx_lane),
  .row_sel     (row_sel),
  .col_pull_hi (col_pull_hi),
  .col_pull_lo (col_pull_lo),
  .col_sample  (col_sample),
  .col_addr    (col_addr),
  .pix_valid   (pix_valid),
  .frame_start (frame_start),
  .frame_end   (frame_end)
);

// File: tb/rs_readout_seq_tb_top.sv
`timescale 1ns/1ps
module rs_readout_seq_tb_top;

  localparam int ROW_W = 10;
  localparam int COL_W = 11;
  localparam int SET_W = 8;
  localparam int SL    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [1:0] pix_mode = 2'd0;
  logic [ROW_W-1:0] cfg_rows = 10'd1;
  logic [COL_W-1:0] cfg_cols = 11'd1;
  logic [SET_W-1:0] cfg_settle = 8'd1;
  logic [ROW_W-1:0] cfg_integ = 10'd0;

  logic busy, row_reset, row_tx, row_sel, col_pull_hi, col_pull_lo;
  logic col_sample, pix_valid, shut_reset, frame_start, frame_end;
  logic [ROW_W-1:0] row_addr, shut_row;
  logic [ROW_W-SL-1:0] fd_group;
  logic [(1<<SL)-1:0] tx_lane;
  logic [COL_W-1:0] col_addr;

  always #2.5 clk = ~clk;

  rs_readout_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .SET_W(SET_W), .SHARE_LOG(SL)) dut_i (
    .clk(clk), .rst(rst), .start(start), .pix_mode(pix_mode),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_settle(cfg_settle),
    .cfg_integ(cfg_integ), .busy(busy), .row_addr(row_addr), .fd_group(fd_group),
    .row_reset(row_reset), .row_tx(row_tx), .tx_lane(tx_lane), .row_sel(row_sel),
    .col_pull_hi(col_pull_hi), .col_pull_lo(col_pull_lo), .col_sample(col_sample),
    .col_addr(col_addr), .pix_valid(pix_valid), .shut_reset(shut_reset),
    .shut_row(shut_row), .frame_start(frame_start), .frame_end(frame_end)
  );

  typedef struct {
    bit busy, rs, tx, sel, hi, lo, smp, pv, fs, fe, sh;
    int col, row, lane, fd, srow, kind;
  } exp_t;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // inputs as seen by the design at the latest rising edge
  bit s_rst = 1, s_start = 0;
  int s_mode, s_rows, s_cols, s_set, s_int;
  always @(posedge clk) begin
    s_rst = rst; s_start = start; s_mode = int'(pix_mode); s_rows = int'(cfg_rows);
    s_cols = int'(cfg_cols); s_set = int'(cfg_settle); s_int = int'(cfg_integ);
  end

  // reference model state
  exp_t q[$];
  int mst = 0;
  int m_mode, m_rows, m_cols, m_set, m_int, m_row;

  function automatic exp_t blank();
    exp_t e;
    e.busy = 0; e.rs = 0; e.tx = 0; e.sel = 0; e.hi = 0; e.lo = 0; e.smp = 0;
    e.pv = 0; e.fs = 0; e.fe = 0; e.sh = 0;
    e.col = 0; e.row = 0; e.lane = 0; e.fd = 0; e.srow = 0; e.kind = 0;
    return e;
  endfunction

  function automatic exp_t rowv();
    exp_t e = blank();
    e.busy = 1; e.row = m_row; e.fd = m_row >> SL;
    return e;
  endfunction

  task automatic push_slot();
    exp_t e;
    int s = (m_set == 0) ? 1 : m_set;
    exp_t first;
    exp_t lst[$];
    if (m_mode == 0) begin
      for (int i = 0; i < s; i++) begin e = rowv(); e.sel = 1; lst.push_back(e); end
      e = rowv(); e.sel = 1; e.smp = 1; lst.push_back(e);
      e = rowv(); e.rs = 1; lst.push_back(e);
    end else if (m_mode == 2) begin
      e = rowv(); e.sel = 1; e.hi = 1; lst.push_back(e);
      e = rowv(); e.tx = 1; e.sel = 1; e.lane = 1 << (m_row % 4); lst.push_back(e);
      for (int i = 0; i < s; i++) begin e = rowv(); e.sel = 1; lst.push_back(e); end
      e = rowv(); e.sel = 1; e.smp = 1; lst.push_back(e);
      e = rowv(); e.sel = 1; e.lo = 1; lst.push_back(e);
    end else begin
      e = rowv(); e.rs = 1; lst.push_back(e);
      e = rowv(); e.tx = 1; e.lane = 1 << (m_row % 4); lst.push_back(e);
      for (int i = 0; i < s; i++) begin e = rowv(); e.sel = 1; lst.push_back(e); end
      e = rowv(); e.sel = 1; e.smp = 1; lst.push_back(e);
    end
    for (int c = 0; c < m_cols; c++) begin e = rowv(); e.pv = 1; e.col = c; lst.push_back(e); end
    first = lst.pop_front();
    first.fs = (m_row == 0);
    if (m_int != 0 && m_int < m_rows) begin
      first.sh = 1; first.srow = (m_row + m_int) % m_rows;
    end
    q.push_back(first);
    foreach (lst[i]) q.push_back(lst[i]);
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    exp_t e;
    exp_t cur;
    string mt, bt;
    if (s_rst) begin
      q.delete(); mst = 0; cur = blank();
    end else begin
      if (q.size() == 0) begin
        if (mst == 1) begin
          if (m_row == m_rows - 1) begin
            e = rowv(); e.fe = 1; q.push_back(e); mst = 2;
          end else if (s_start) begin
            m_row++; push_slot();
          end else begin
            e = blank(); e.kind = 1; q.push_back(e); mst = 0;
          end
        end else if (s_start) begin
          m_mode = s_mode; m_rows = s_rows; m_cols = s_cols; m_set = s_set; m_int = s_int;
          m_row = 0; push_slot(); mst = 1;
        end else begin
          q.push_back(blank());
        end
      end
      cur = q.pop_front();
    end
    if (!done) begin
      mt = (m_mode == 0) ? "R3" : (m_mode == 2) ? "R5" : "R4";
      if (mst != 0 && (s_mode != m_mode || s_cols != m_cols || s_rows != m_rows ||
                       s_set != m_set || s_int != m_int)) mt = "R12";
      bt = (cur.kind == 1) ? "R11" : "R1";
      chk(bt, "busy", int'(busy), int'(cur.busy));
      chk(mt, "row_reset", int'(row_reset), int'(cur.rs));
      chk(mt, "row_tx", int'(row_tx), int'(cur.tx));
      chk(mt, "row_sel", int'(row_sel), int'(cur.sel));
      chk(mt, "col_pull_hi", int'(col_pull_hi), int'(cur.hi));
      chk(mt, "col_pull_lo", int'(col_pull_lo), int'(cur.lo));
      chk("R6", "col_sample", int'(col_sample), int'(cur.smp));
      chk("R7", "pix_valid", int'(pix_valid), int'(cur.pv));
      chk("R7", "col_addr", int'(col_addr), cur.col);
      chk("R8", "row_addr", int'(row_addr), cur.row);
      chk("R8", "tx_lane", int'(tx_lane), cur.lane);
      chk("R8", "fd_group", int'(fd_group), cur.fd);
      chk("R9", "shut_reset", int'(shut_reset), int'(cur.sh));
      chk("R9", "shut_row", int'(shut_row), cur.srow);
      chk("R2", "frame_start", int'(frame_start), int'(cur.fs));
      chk("R10", "frame_end", int'(frame_end), int'(cur.fe));
    end
  end

  task automatic setup(int m, int n, int c, int s, int i);
    @(posedge clk); #1;
    pix_mode = 2'(m); cfg_rows = ROW_W'(n); cfg_cols = COL_W'(c);
    cfg_settle = SET_W'(s); cfg_integ = ROW_W'(i);
  endtask

  task automatic set_start(bit v);
    @(posedge clk); #1; start = v;
  endtask

  task automatic idle_for(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    idle_for(4);
    #1 rst = 0;
    idle_for(5);                          // R1 idle after reset
    // R4 pinned diode, shutter two rows ahead, two frames back to back (R10)
    setup(1, 5, 6, 3, 2);
    set_start(1);
    idle_for(95);
    set_start(0);                         // R11 stop mid-frame
    idle_for(40);
    // R3 three-transistor, settle 0, no shutter; mid-frame config change (R12)
    setup(0, 4, 3, 0, 0);
    set_start(1);
    idle_for(10);
    setup(2, 4, 7, 2, 0);
    idle_for(80);
    set_start(0);
    idle_for(60);
    // R5 shared diffusion, nine rows so lanes and groups wrap, shutter wraps (R9)
    setup(2, 9, 4, 2, 8);
    set_start(1);
    idle_for(200);
    set_start(0);
    idle_for(40);
    // code 3 behaves as pinned diode, integ equal to rows gives no shutter
    setup(3, 3, 2, 1, 3);
    set_start(1);
    idle_for(40);
    set_start(0);
    idle_for(20);
    // one-cycle start pulse: one row, then idle (R11)
    setup(1, 2, 2, 1, 1);
    set_start(1);
    set_start(0);
    idle_for(30);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL R1 watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

endmodule